// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table that turns the upper bits of an effective address into a stored virtual-segment word. Every entry holds two 64-bit words: an ESID word, which carries the effective segment number and a valid flag, and a VSID word, which carries a two-bit segment-size field and the virtual segment number that the page walker consumes. Entries can describe 256 MB or 1 TB segments, and the two sizes can be mixed freely inside one table.

A lookup is purely combinational. It returns a hit flag, the index of the matching entry and the VSID word of that entry. The remaining ports change state on the next rising clock edge. The store port checks the slot and size encodings before it writes. The indexed read ports return either word of a chosen slot. Two invalidate commands clear entries: one clears the entry that matches a given address, and the other clears every entry except entry 0. Each invalidate raises a one-cycle TLB-flush request, but only when it actually cleared a valid entry. A configuration input sets whether 1 TB segments may be stored.

Top module: `seg_lookaside`

## Requirements
- R1: A lookup hits an entry in two cases. In the first, the entry's ESID word equals the effective address with bits 27:0 cleared and bit 27 set, and its size field (VSID bits 63:62) is 2'b00, meaning 256 MB. In the second, the entry's ESID word equals the address with bits 39:0 cleared and bit 27 set, and its size field is 2'b01, meaning 1 TB. On a hit, `lk_vsid` carries the VSID word of the matching entry.
- R2: When several entries hit, the entry with the lowest index is reported.
- R3: A store takes its slot from ESID-word bits 11:0. If any of those bits at or above log2(NUM_ENTRIES) is set, the store is rejected: `wr_err` rises in the same cycle and no entry changes.
- R4: A store whose size field is 2'b10 or 2'b11 is rejected with `wr_err`, and nothing is written.
- R5: A store whose size field is 2'b01 (1 TB) is rejected with `wr_err` while `cfg_1t_en` is low.
- R6: An accepted store keeps only bits 63:27 of the ESID word, so the slot bits and the bits between them and bit 27 are stored as zero. The VSID word is stored unchanged.
- R7: An indexed read of a slot below NUM_ENTRIES returns the stored words combinationally. A read of a slot at or above NUM_ENTRIES raises `rd_err` and returns zero on both data outputs.
- R8: Invalidate-by-address clears bit 27 of the entry that matches the address under the rules of R1 and R2. In the next cycle it raises `flush_req`. When no entry matches, neither the table nor `flush_req` changes.
- R9: Invalidate-all clears bit 27 of every entry except entry 0. In the next cycle it raises `flush_req`, but only if at least one of those entries was valid.
- R10: When commands arrive in the same cycle, invalidate-all wins over invalidate-by-address, and invalidate-by-address wins over a store. A store that loses is dropped without `wr_err`. `flush_req` is high for exactly one cycle after each invalidate that flushes.
- R11: Reset clears every word of every entry to zero, which leaves all entries invalid, and clears `flush_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_1t_en | input | 1 | Allows 1 TB segments to be stored |
| lk_ea | input | 64 | Effective address to look up |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_idx | output | IDX_W | Index of the matching entry |
| lk_vsid | output | 64 | VSID word of the matching entry |
| wr_en | input | 1 | Store request |
| wr_esid_word | input | 64 | ESID word, with the slot in bits 11:0 |
| wr_vsid_word | input | 64 | VSID word, with the size in bits 63:62 |
| wr_err | output | 1 | Store rejected as invalid |
| rd_en | input | 1 | Indexed read request |
| rd_slot | input | 12 | Slot to read |
| rd_esid | output | 64 | ESID word of the slot being read |
| rd_vsid | output | 64 | VSID word of the slot being read |
| rd_err | output | 1 | Read slot is out of range |
| inv_addr_en | input | 1 | Invalidate the entry that matches inv_addr |
| inv_addr | input | 64 | Address for invalidate-by-address |
| inv_all_en | input | 1 | Invalidate all entries except entry 0 |
| flush_req | output | 1 | TLB-flush request, one cycle |

## Verification
The lookup outputs, `wr_err`, `rd_err` and the read data respond in the same cycle as their inputs. The bench drives these inputs on the falling edge and samples the outputs 1 ns later, before any rising edge. A store or an invalidate changes the table at the next rising edge, and `flush_req` is registered at that same edge. The bench therefore looks for the table change and for `flush_req` at the following falling edge, and checks one falling edge after that to confirm that `flush_req` has dropped again.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int SEG_WORD_W    = 64;
   localparam int SEG_VALID_BIT = 27;
   localparam int SEG_SHIFT_256 = 28;
   localparam int SEG_SHIFT_1T  = 40;
   localparam int SEG_SIZE_HI   = 63;
   localparam int SEG_SIZE_LO   = 62;
   localparam int SEG_SLOT_W    = 12;

   typedef logic [SEG_WORD_W-1:0] seg_word_t;

   typedef enum logic [1:0] {
      SEG_SZ_256M = 2'b00,
      SEG_SZ_1T   = 2'b01,
      SEG_SZ_RSV2 = 2'b10,
      SEG_SZ_RSV3 = 2'b11
   } seg_size_e;

   localparam seg_word_t SEG_VALID_MASK = seg_word_t'(1) << SEG_VALID_BIT;
   localparam seg_word_t SEG_MASK_256   = ~((seg_word_t'(1) << SEG_SHIFT_256) - 1);
   localparam seg_word_t SEG_MASK_1T    = ~((seg_word_t'(1) << SEG_SHIFT_1T) - 1);
   localparam seg_word_t SEG_KEEP_MASK  = ~((seg_word_t'(1) << SEG_VALID_BIT) - 1);

   function automatic seg_word_t seg_key(input seg_word_t ea, input seg_word_t seg_mask);
      return (ea & seg_mask) | SEG_VALID_MASK;
   endfunction

   function automatic seg_size_e seg_size_of(input seg_word_t vsid);
      return seg_size_e'(vsid[SEG_SIZE_HI:SEG_SIZE_LO]);
   endfunction
endpackage

// File: rtl/seg_key_match.sv
module seg_key_match
   import seg_pkg::*;
#(
   parameter int NUM_ENTRIES = 64
) (
   input  seg_word_t                         ea,
   input  logic [NUM_ENTRIES-1:0][SEG_WORD_W-1:0] esid_tab,
   input  logic [NUM_ENTRIES-1:0][SEG_WORD_W-1:0] vsid_tab,
   output logic [NUM_ENTRIES-1:0]            hit_vec
);
   seg_word_t key_256;
   seg_word_t key_1t;

   assign key_256 = seg_key(ea, SEG_MASK_256);
   assign key_1t  = seg_key(ea, SEG_MASK_1T);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      seg_size_e sz;
      logic      m_256;
      logic      m_1t;
      assign sz    = seg_size_of(vsid_tab[g]);
      assign m_256 = (esid_tab[g] == key_256) && (sz == SEG_SZ_256M);
      assign m_1t  = (esid_tab[g] == key_1t)  && (sz == SEG_SZ_1T);
      assign hit_vec[g] = m_256 || m_1t;
   end
endmodule

// File: rtl/seg_prio_enc.sv
module seg_prio_enc #(
   parameter int NUM_ENTRIES = 64,
   localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
   input  logic [NUM_ENTRIES-1:0] req_vec,
   output logic                   any,
   output logic [IDX_W-1:0]       idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (req_vec[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/seg_store_check.sv
module seg_store_check
   import seg_pkg::*;
#(
   parameter int NUM_ENTRIES = 64,
   localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
   input  seg_word_t        esid_word,
   input  seg_word_t        vsid_word,
   input  logic             cfg_1t_en,
   output logic [IDX_W-1:0] slot,
   output logic             bad
);
   localparam logic [SEG_SLOT_W-1:0] SLOT_RSV = ~SEG_SLOT_W'(NUM_ENTRIES - 1);

   logic [SEG_SLOT_W-1:0] slot_field;
   seg_size_e             sz;
   logic                  bad_slot;
   logic                  bad_size;
   logic                  bad_1t;

   assign slot_field = esid_word[SEG_SLOT_W-1:0];
   assign slot       = slot_field[IDX_W-1:0];
   assign sz         = seg_size_of(vsid_word);
   assign bad_slot   = |(slot_field & SLOT_RSV);
   assign bad_size   = (sz != SEG_SZ_256M) && (sz != SEG_SZ_1T);
   assign bad_1t     = (sz == SEG_SZ_1T) && !cfg_1t_en;
   assign bad        = bad_slot || bad_size || bad_1t;
endmodule

// File: rtl/seg_entry_file.sv
module seg_entry_file
   import seg_pkg::*;
#(
   parameter int NUM_ENTRIES = 64,
   localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_inv_all,
   input  logic             do_inv_one,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic             do_store,
   input  logic [IDX_W-1:0] st_slot,
   input  seg_word_t        st_esid,
   input  seg_word_t        st_vsid,
   output logic [NUM_ENTRIES-1:0][SEG_WORD_W-1:0] esid_tab,
   output logic [NUM_ENTRIES-1:0][SEG_WORD_W-1:0] vsid_tab,
   output logic             flush
);
   logic [NUM_ENTRIES-1:0] valid_now;
   logic                   upper_valid;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_v
      assign valid_now[g] = esid_tab[g][SEG_VALID_BIT];
   end
   assign upper_valid = |valid_now[NUM_ENTRIES-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esid_tab <= '0;
         vsid_tab <= '0;
         flush    <= 1'b0;
      end else begin
         flush <= 1'b0;
         if (do_inv_all) begin
            for (int i = 1; i < NUM_ENTRIES; i++) begin
               esid_tab[i][SEG_VALID_BIT] <= 1'b0;
            end
            flush <= upper_valid;
         end else if (do_inv_one) begin
            esid_tab[inv_idx][SEG_VALID_BIT] <= 1'b0;
            flush <= 1'b1;
         end else if (do_store) begin
            esid_tab[st_slot] <= st_esid & SEG_KEEP_MASK;
            vsid_tab[st_slot] <= st_vsid;
         end
      end
   end
endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
   import seg_pkg::*;
#(
   parameter int NUM_ENTRIES = 64,
   localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_1t_en,
   input  logic [63:0]      lk_ea,
   output logic             lk_hit,
   output logic [IDX_W-1:0] lk_idx,
   output logic [63:0]      lk_vsid,
   input  logic             wr_en,
   input  logic [63:0]      wr_esid_word,
   input  logic [63:0]      wr_vsid_word,
   output logic             wr_err,
   input  logic             rd_en,
   input  logic [11:0]      rd_slot,
   output logic [63:0]      rd_esid,
   output logic [63:0]      rd_vsid,
   output logic             rd_err,
   input  logic             inv_addr_en,
   input  logic [63:0]      inv_addr,
   input  logic             inv_all_en,
   output logic             flush_req
);
   if (NUM_ENTRIES < 2 || NUM_ENTRIES > (1 << SEG_SLOT_W)) begin : g_bad_count
      $error("seg_lookaside: NUM_ENTRIES out of range");
   end
   if ((NUM_ENTRIES & (NUM_ENTRIES - 1)) != 0) begin : g_bad_pow2
      $error("seg_lookaside: NUM_ENTRIES must be a power of two");
   end

   logic [NUM_ENTRIES-1:0][SEG_WORD_W-1:0] esid_tab;
   logic [NUM_ENTRIES-1:0][SEG_WORD_W-1:0] vsid_tab;
   logic [NUM_ENTRIES-1:0] valid_vec;
   logic [NUM_ENTRIES-1:0] lk_vec;
   logic [NUM_ENTRIES-1:0] inv_vec;
   logic                   inv_hit;
   logic [IDX_W-1:0]       inv_idx;
   logic [IDX_W-1:0]       st_slot;
   logic                   st_bad;
   logic                   cmd_inv_one;
   logic                   cmd_store;
   logic                   rd_ok;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_valid
      assign valid_vec[g] = esid_tab[g][SEG_VALID_BIT];
   end

   // Two match planes: one serves the lookup port, one the invalidate port.
   seg_key_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_match (
      .ea(lk_ea), .esid_tab(esid_tab), .vsid_tab(vsid_tab), .hit_vec(lk_vec));
   seg_prio_enc #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_enc (
      .req_vec(lk_vec), .any(lk_hit), .idx(lk_idx));

   seg_key_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_inv_match (
      .ea(inv_addr), .esid_tab(esid_tab), .vsid_tab(vsid_tab), .hit_vec(inv_vec));
   seg_prio_enc #(.NUM_ENTRIES(NUM_ENTRIES)) u_inv_enc (
      .req_vec(inv_vec), .any(inv_hit), .idx(inv_idx));

   seg_store_check #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk_st (
      .esid_word(wr_esid_word), .vsid_word(wr_vsid_word), .cfg_1t_en(cfg_1t_en),
      .slot(st_slot), .bad(st_bad));

   assign cmd_inv_one = inv_addr_en && !inv_all_en && inv_hit;
   assign cmd_store   = wr_en && !inv_all_en && !inv_addr_en;
   assign wr_err      = cmd_store && st_bad;

   seg_entry_file #(.NUM_ENTRIES(NUM_ENTRIES)) u_file (
      .clk(clk), .rst_n(rst_n),
      .do_inv_all(inv_all_en), .do_inv_one(cmd_inv_one), .inv_idx(inv_idx),
      .do_store(cmd_store && !st_bad), .st_slot(st_slot),
      .st_esid(wr_esid_word), .st_vsid(wr_vsid_word),
      .esid_tab(esid_tab), .vsid_tab(vsid_tab), .flush(flush_req));

   assign lk_vsid = lk_hit ? vsid_tab[lk_idx] : '0;

   assign rd_err  = rd_en && (rd_slot >= 12'(NUM_ENTRIES));
   assign rd_ok   = rd_en && !rd_err;
   assign rd_esid = rd_ok ? esid_tab[rd_slot[IDX_W-1:0]] : '0;
   assign rd_vsid = rd_ok ? vsid_tab[rd_slot[IDX_W-1:0]] : '0;
endmodule

// File: rtl/seg_lookaside_chk.sv
module seg_lookaside_chk #(
   parameter int NUM_ENTRIES = 64,
   localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   lk_hit,
   input logic [IDX_W-1:0]       lk_idx,
   input logic                   wr_en,
   input logic                   wr_err,
   input logic                   rd_err,
   input logic [63:0]            rd_esid,
   input logic [63:0]            rd_vsid,
   input logic                   inv_addr_en,
   input logic                   inv_all_en,
   input logic                   flush_req,
   input logic [NUM_ENTRIES-1:0] valid_vec
);
   // R1
   hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> valid_vec[lk_idx]);

   // R3
   err_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> wr_en);

   // R7
   bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (rd_esid == '0) && (rd_vsid == '0));

   // R9
   inv_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all_en |=> (valid_vec[NUM_ENTRIES-1:1] == '0));

   // R9
   entry0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all_en |=> (valid_vec[0] == $past(valid_vec[0])));

   // R10
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> $past(inv_all_en || inv_addr_en));

   // R10
   flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !$past(inv_all_en || inv_addr_en, 1)) |-> 1'b0);
endmodule

bind seg_lookaside seg_lookaside_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_seg_chk (
   .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_idx(lk_idx),
   .wr_en(wr_en), .wr_err(wr_err), .rd_err(rd_err),
   .rd_esid(rd_esid), .rd_vsid(rd_vsid),
   .inv_addr_en(inv_addr_en), .inv_all_en(inv_all_en),
   .flush_req(flush_req), .valid_vec(valid_vec));

// File: tb/test_seg_lookaside.sv
`timescale 1ns/1ps
module test_seg_lookaside;
   localparam int N = 64;
   localparam logic [63:0] V = 64'h0000_0000_0800_0000;
   localparam logic [63:0] KEEP = 64'hFFFF_FFFF_F800_0000;
   localparam int NV = 9;

   // Store vectors: ESID word, VSID word, cfg_1t_en, expected wr_err.
   localparam logic [63:0] TV_E [NV] = '{
      64'h0000_0000_1000_0000 | V | 64'd0,
      64'h0000_0200_0000_0000 | V | 64'd5,
      64'h0000_0000_4000_0000 | V | 64'h40,
      64'h0000_0000_5000_0000 | V | 64'h800,
      64'h0000_0000_6000_0000 | V | 64'd10,
      64'h0000_0000_7000_0000 | V | 64'd11,
      64'h0000_0400_0000_0000 | V | 64'd7,
      64'h0000_0000_2000_0000 | V | 64'h1000 | 64'd63,
      64'h0000_0000_2000_0000 | V | 64'd3};
   localparam logic [63:0] TV_V [NV] = '{
      64'h0000_0000_0000_A100,
      64'h4000_0000_0000_B500,
      64'h0000_0000_0000_0001,
      64'h0000_0000_0000_0002,
      64'h8000_0000_0000_0003,
      64'hC000_0000_0000_0004,
      64'h4000_0000_0000_0005,
      64'h0000_0000_0000_C300,
      64'h0000_0000_0000_D300};
   localparam logic TV_C [NV] = '{1, 1, 1, 1, 1, 1, 0, 1, 1};
   localparam logic TV_ERR [NV] = '{0, 0, 1, 1, 1, 1, 1, 0, 0};

   logic clk = 0, rst_n = 0, cfg_1t_en = 1;
   logic [63:0] lk_ea = 0;
   logic lk_hit;
   logic [5:0] lk_idx;
   logic [63:0] lk_vsid;
   logic wr_en = 0;
   logic [63:0] wr_esid_word = 0, wr_vsid_word = 0;
   logic wr_err;
   logic rd_en = 0;
   logic [11:0] rd_slot = 0;
   logic [63:0] rd_esid, rd_vsid;
   logic rd_err;
   logic inv_addr_en = 0;
   logic [63:0] inv_addr = 0;
   logic inv_all_en = 0;
   logic flush_req;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   seg_lookaside #(.NUM_ENTRIES(N)) i_seg_lookaside (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic store(input logic [63:0] e, input logic [63:0] v, input logic c,
                        output logic err);
      @(negedge clk);
      wr_en = 1; wr_esid_word = e; wr_vsid_word = v; cfg_1t_en = c;
      #1 err = wr_err;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic look(input logic [63:0] ea, output logic h, output logic [5:0] i,
                       output logic [63:0] vs);
      @(negedge clk);
      lk_ea = ea;
      #1 h = lk_hit; i = lk_idx; vs = lk_vsid;
   endtask

   task automatic rd(input logic [11:0] s, output logic [63:0] e, output logic [63:0] v,
                     output logic err);
      @(negedge clk);
      rd_en = 1; rd_slot = s;
      #1 e = rd_esid; v = rd_vsid; err = rd_err;
      @(negedge clk);
      rd_en = 0;
   endtask

   // Issue an invalidate; return flush one and two cycles later.
   task automatic inv(input logic all, input logic [63:0] a, output logic f1, output logic f2);
      @(negedge clk);
      inv_all_en = all; inv_addr_en = !all; inv_addr = a;
      @(negedge clk);
      inv_all_en = 0; inv_addr_en = 0;
      f1 = flush_req;
      @(negedge clk);
      f2 = flush_req;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic err, h, f1, f2;
      logic [5:0] ix;
      logic [63:0] vs, e, v;

      // R11 reset state
      repeat (3) @(negedge clk);
      rst_n = 1;
      look(64'h0, h, ix, vs);
      check("R11 lookup miss after reset", h, 0);
      check("R11 flush low after reset", flush_req, 0);
      rd(12'd0, e, v, err);
      check("R11 slot0 esid zero", e, 0);
      check("R11 slot0 vsid zero", v, 0);

      // R3 R4 R5 R6 store vector table
      for (int k = 0; k < NV; k++) begin
         logic [11:0] s;
         store(TV_E[k], TV_V[k], TV_C[k], err);
         check("R3/R4/R5 wr_err", err, TV_ERR[k]);
         s = TV_E[k][11:0];
         if (s < N) begin
            rd(s, e, v, err);
            check("R6 esid readback", e, TV_ERR[k] ? 64'h0 : (TV_E[k] & KEEP));
            check("R6 vsid readback", v, TV_ERR[k] ? 64'h0 : TV_V[k]);
         end
      end

      // R1 256 MB and 1 TB hits, misses
      look(64'h0000_0000_1ABC_D000, h, ix, vs);
      check("R1 256M hit", h, 1); check("R1 256M idx", ix, 0);
      check("R1 256M vsid", vs, 64'h0000_0000_0000_A100);
      look(64'h0000_0234_5678_9000, h, ix, vs);
      check("R1 1T hit", h, 1); check("R1 1T idx", ix, 5);
      check("R1 1T vsid", vs, 64'h4000_0000_0000_B500);
      look(64'h0000_0300_0000_0000, h, ix, vs);
      check("R1 1T neighbour miss", h, 0);
      look(64'h0000_0000_3000_0000, h, ix, vs);
      check("R1 256M neighbour miss", h, 0);

      // R2 lowest index wins (slots 3 and 63 share a segment)
      look(64'h0000_0000_2000_0010, h, ix, vs);
      check("R2 prio idx", ix, 3);
      check("R2 prio vsid", vs, 64'h0000_0000_0000_D300);

      // R7 out-of-range read
      rd(12'd64, e, v, err);
      check("R7 rd_err", err, 1); check("R7 esid zero", e, 0); check("R7 vsid zero", v, 0);
      rd(12'd63, e, v, err);
      check("R7 in-range no err", err, 0);

      // R8 invalidate by address
      inv(0, 64'h0000_0234_0000_0000, f1, f2);
      check("R8 flush on hit", f1, 1);
      check("R10 flush one cycle", f2, 0);
      look(64'h0000_0234_5678_9000, h, ix, vs);
      check("R8 entry gone", h, 0);
      rd(12'd5, e, v, err);
      check("R8 valid cleared", e, 64'h0000_0200_0000_0000);
      inv(0, 64'h0000_0000_7000_0000, f1, f2);
      check("R8 no flush on miss", f1, 0);
      look(64'h0000_0000_1000_0000, h, ix, vs);
      check("R8 miss leaves entry0", h, 1);

      // R10 invalidate-all beats a store in the same cycle
      @(negedge clk);
      inv_all_en = 1; wr_en = 1; cfg_1t_en = 1;
      wr_esid_word = 64'h0000_0000_9000_0000 | V | 64'd20; wr_vsid_word = 64'h0;
      #1 check("R10 losing store no wr_err", wr_err, 0);
      @(negedge clk);
      inv_all_en = 0; wr_en = 0;
      check("R9 flush after inv-all", flush_req, 1);
      rd(12'd20, e, v, err);
      check("R10 losing store dropped", e, 0);

      // R9 entry 0 survives, others cleared
      look(64'h0000_0000_1000_0000, h, ix, vs);
      check("R9 entry0 kept", h, 1);
      look(64'h0000_0000_2000_0010, h, ix, vs);
      check("R9 others cleared", h, 0);
      rd(12'd63, e, v, err);
      check("R9 slot63 invalid", e, 64'h0000_0000_2000_0000);
      inv(1, 64'h0, f1, f2);
      check("R9 no flush when only entry0 valid", f1, 0);

      // R11 reset mid-run
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      look(64'h0000_0000_1000_0000, h, ix, vs);
      check("R11 reset clears entry0", h, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule